// File: doc/BRIEF.md
# Serial Error-Word Receiver

This block takes short error samples that a power-stage front end sends over a single data wire with no clock beside it. The wire rests at its idle level between samples, and a sample can arrive at any time, so each one opens with a start bit at the opposite level. The receiver oversamples the wire with its own system clock and runs the raw input through a small synchronizer. It confirms the start bit, then shifts in a fixed number of data bits, most significant first, at two clocks per bit. The finished word is placed on a parallel output together with a one-clock valid strobe.

A start bit that has gone back to idle by its confirming sample is reported as a framing error, and no word is produced. After a word has been captured, the receiver ignores the wire until it has stayed idle for one full bit time, so that a wire held at the start level cannot open a new frame. Word width, clocks per bit, synchronizer depth, idle polarity and bit order are parameters. The defaults are six bits, two clocks per bit, two synchronizer stages, idle high and most-significant bit first.

Top module: `errword_rx`

## Requirements
- R1: While reset is low, and on the first clock after its release, `word_o` reads 0 and both `word_vld_o` and `frame_err_o` read 0. A reset in the middle of a frame discards that partial frame.
- R2: With the default polarity the wire idles high and a start bit is low. A frame opens when the synchronized wire moves from idle to low while the receiver is armed.
- R3: After the start bit come exactly 6 data bits of 2 clocks each. The first data bit lands in `word_o[5]` and the last in `word_o[0]`. Two consecutive valid strobes are never closer than 14 clocks apart.
- R4: The start bit is judged on its second clock. If the wire is back at idle then, `frame_err_o` is high for exactly one clock and no word is produced.
- R5: Each data bit is taken from the second clock of its slot, so a wrong level in the first clock of a slot does not change the received bit.
- R6: When the last bit has been captured, `word_o` takes the new word and `word_vld_o` is high for exactly one clock. `word_o` does not change again until the next strobe.
- R7: After a word, the receiver opens no frame until the wire has been idle for 2 clocks in a row. A wire held at the start level after a word produces no extra word.
- R8: `word_vld_o` and `frame_err_o` are never high in the same clock.
- R9: A new start bit that follows the last data bit after exactly one bit time (2 clocks) of idle is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used to sample the wire |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data wire, not synchronous to `clk` |
| word_o | output | DATA_W | Last word received, first bit received in the MSB |
| word_vld_o | output | 1 | One-clock strobe that marks a new `word_o` |
| frame_err_o | output | 1 | One-clock strobe for a start bit that failed confirmation |

## Verification
Two things can happen in the same clock: the strobe that presents a finished word, and the first clock of the idle count that re-arms start detection. The bench provokes this by sending frames separated by exactly one bit time of idle. The scoreboard must then see both words, in order and uncorrupted. A second run holds the wire at the start level straight after a word ends, then releases it. Here the scoreboard must see no extra word and no framing error, which shows that the overlap of word completion and re-arming does not open a frame too early.

// File: rtl/errword_rx_pkg.sv
package errword_rx_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_RECOV = 2'd3
   } rx_state_e;

   function automatic int unsigned cnt_width(input int unsigned span);
      return (span <= 2) ? 1 : $clog2(span);
   endfunction

endpackage

// File: rtl/errword_rx_sync.sv
module errword_rx_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_in};
   end

   assign q_out = chain_q[STAGES-1];

endmodule

// File: rtl/errword_rx_framer.sv
module errword_rx_framer
   import errword_rx_pkg::*;
#(
   parameter int unsigned DATA_W      = 6,
   parameter int unsigned CYC_PER_BIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_act,
   output logic take_bit,
   output logic word_done,
   output logic false_start
);

   localparam int unsigned PH_W  = cnt_width(CYC_PER_BIT);
   localparam int unsigned BIT_W = cnt_width(DATA_W);
   localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(CYC_PER_BIT - 1);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

   rx_state_e        state_q;
   logic [PH_W-1:0]  ph_q;
   logic [PH_W-1:0]  gap_q;
   logic [BIT_W-1:0] bit_q;
   logic             act_d_q;
   logic             ph_end;
   logic             bit_end;
   logic             start_edge;

   assign ph_end     = (ph_q == PH_LAST);
   assign bit_end    = (bit_q == BIT_LAST);
   assign start_edge = line_act && !act_d_q;

   assign take_bit    = (state_q == RX_DATA) && ph_end;
   assign word_done   = take_bit && bit_end;
   assign false_start = (state_q == RX_START) && ph_end && !line_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_d_q <= 1'b0;
      else        act_d_q <= line_act;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         ph_q    <= '0;
         gap_q   <= '0;
         bit_q   <= '0;
      end else begin
         unique case (state_q)
            RX_IDLE: begin
               if (start_edge) begin
                  state_q <= RX_START;
                  ph_q    <= PH_W'(1);
               end
            end
            RX_START: begin
               if (ph_end) begin
                  ph_q  <= '0;
                  bit_q <= '0;
                  state_q <= line_act ? RX_DATA : RX_IDLE;
               end else begin
                  ph_q <= ph_q + PH_W'(1);
               end
            end
            RX_DATA: begin
               if (ph_end) begin
                  ph_q <= '0;
                  if (bit_end) begin
                     state_q <= RX_RECOV;
                     gap_q   <= '0;
                  end else begin
                     bit_q <= bit_q + BIT_W'(1);
                  end
               end else begin
                  ph_q <= ph_q + PH_W'(1);
               end
            end
            RX_RECOV: begin
               if (line_act) begin
                  gap_q <= '0;
               end else if (gap_q == PH_LAST) begin
                  state_q <= RX_IDLE;
                  gap_q   <= '0;
               end else begin
                  gap_q <= gap_q + PH_W'(1);
               end
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/errword_rx_shifter.sv
module errword_rx_shifter #(
   parameter int unsigned DATA_W    = 6,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_bit,
   input  logic              word_done,
   input  logic              bit_in,
   output logic [DATA_W-1:0] word_q,
   output logic              vld_q
);

   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] sh_next;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sh_next = {sh_q[DATA_W-2:0], bit_in};
      end else begin : g_lsb
         assign sh_next = {bit_in, sh_q[DATA_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         word_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= word_done;
         if (take_bit)  sh_q   <= sh_next;
         if (word_done) word_q <= sh_next;
      end
   end

endmodule

// File: rtl/errword_rx.sv
module errword_rx #(
   parameter int unsigned DATA_W      = 6,
   parameter int unsigned CYC_PER_BIT = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          IDLE_HIGH   = 1'b1,
   parameter bit          MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_in,
   output logic [DATA_W-1:0] word_o,
   output logic              word_vld_o,
   output logic              frame_err_o
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("errword_rx: DATA_W must be at least 2");
      end
      if (CYC_PER_BIT < 2) begin : g_bad_rate
         $error("errword_rx: CYC_PER_BIT must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("errword_rx: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic line_q;
   logic line_act;
   logic take_bit;
   logic word_done;
   logic false_start;
   logic err_q;

   errword_rx_sync #(
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(IDLE_HIGH)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_in (ser_in),
      .q_out(line_q)
   );

   generate
      if (IDLE_HIGH) begin : g_idle_hi
         assign line_act = ~line_q;
      end else begin : g_idle_lo
         assign line_act = line_q;
      end
   endgenerate

   errword_rx_framer #(
      .DATA_W     (DATA_W),
      .CYC_PER_BIT(CYC_PER_BIT)
   ) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_act   (line_act),
      .take_bit   (take_bit),
      .word_done  (word_done),
      .false_start(false_start)
   );

   errword_rx_shifter #(
      .DATA_W   (DATA_W),
      .MSB_FIRST(MSB_FIRST)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_bit (take_bit),
      .word_done(word_done),
      .bit_in   (line_q),
      .word_q   (word_o),
      .vld_q    (word_vld_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= false_start;
   end

   assign frame_err_o = err_q;

endmodule

// File: rtl/errword_rx_chk.sv
module errword_rx_chk #(
   parameter int unsigned DATA_W      = 6,
   parameter int unsigned CYC_PER_BIT = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] word_o,
   input logic              word_vld_o,
   input logic              frame_err_o
);

   localparam int unsigned MIN_SPACE = (DATA_W + 1) * CYC_PER_BIT - 1;
   localparam int unsigned SPC_W     = $clog2(MIN_SPACE + 2);

   logic [SPC_W-1:0] since_vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          since_vld_q <= '0;
      else if (word_vld_o)                 since_vld_q <= '0;
      else if (since_vld_q <= SPC_W'(MIN_SPACE)) since_vld_q <= since_vld_q + SPC_W'(1);
   end

   AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld_o |=> !word_vld_o); // R6

   AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld_o |-> $stable(word_o)); // R6

   AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |=> !frame_err_o); // R4

   AST_NO_VLD_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      !(word_vld_o && frame_err_o)); // R8

   AST_VLD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld_o |-> (since_vld_q >= SPC_W'(MIN_SPACE))); // R3

endmodule

bind errword_rx errword_rx_chk #(
   .DATA_W     (DATA_W),
   .CYC_PER_BIT(CYC_PER_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .word_o     (word_o),
   .word_vld_o (word_vld_o),
   .frame_err_o(frame_err_o)
);

// File: tb/errword_rx_test.sv
`timescale 1ns/1ps
module errword_rx_test;

   localparam int W   = 6;
   localparam int CPB = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ser_in = 1'b1;
   logic [W-1:0] word_o;
   logic         word_vld_o;
   logic         frame_err_o;

   int checks = 0;
   int fails  = 0;
   int err_exp = 0;
   int err_seen = 0;
   bit done = 1'b0;
   bit prev_vld = 1'b0;
   logic [W-1:0] exp_q[$];
   logic [W-1:0] last_sent = '0;

   always #2.5 clk = ~clk;

   errword_rx uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ser_in     (ser_in),
      .word_o     (word_o),
      .word_vld_o (word_vld_o),
      .frame_err_o(frame_err_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic v, input int n);
      ser_in = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_word(input logic [W-1:0] w, input logic [W-1:0] glitch);
      exp_q.push_back(w);
      last_sent = w;
      drive(1'b0, CPB);
      for (int i = W - 1; i >= 0; i--) begin
         if (glitch[i]) begin
            drive(~w[i], 1);
            drive(w[i], CPB - 1);
         end else begin
            drive(w[i], CPB);
         end
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst_n) begin
         prev_vld <= 1'b0;
      end else begin
         if (word_vld_o) begin
            chk(!prev_vld, "R6 strobe width", 1, 0);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3 unexpected word", int'(word_o), 0);
            end else begin
               logic [W-1:0] e;
               e = exp_q.pop_front();
               chk(word_o == e, "R3 word value", int'(word_o), int'(e));
            end
         end
         if (frame_err_o) err_seen++;
         prev_vld <= word_vld_o;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (4) @(negedge clk);
      chk(word_o == '0 && !word_vld_o && !frame_err_o, "R1 in reset",
          {word_o, word_vld_o, frame_err_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(word_o == '0 && !word_vld_o && !frame_err_o, "R1 after release",
          {word_o, word_vld_o, frame_err_o}, 0);
      drive(1'b1, 6);

      // R2 R3 plain frames with bit-order patterns
      send_word(6'b100000, '0); drive(1'b1, 6);
      send_word(6'b000001, '0); drive(1'b1, 6);
      send_word(6'b101101, '0); drive(1'b1, 6);
      chk(word_o == last_sent, "R3 MSB first", int'(word_o), int'(last_sent));

      // R9 minimum gap: strobe and re-arm overlap
      send_word(6'b111111, '0); drive(1'b1, CPB);
      send_word(6'b010101, '0); drive(1'b1, CPB);
      send_word(6'b011110, '0); drive(1'b1, 6);
      chk(exp_q.size() == 0, "R9 back-to-back received", exp_q.size(), 0);

      // R5 first-cycle glitch in every slot
      send_word(6'b110100, 6'b111111); drive(1'b1, 6);
      chk(word_o == 6'b110100, "R5 second-cycle sample", int'(word_o), 'h34);

      // R4 false start
      drive(1'b0, 1); drive(1'b1, 8);
      err_exp++;
      chk(err_seen == err_exp, "R4 framing error", err_seen, err_exp);
      chk(word_o == 6'b110100, "R4 no word on error", int'(word_o), 'h34);
      send_word(6'b011011, '0); drive(1'b1, 6);

      // R7 wire stuck at start level after a word
      send_word(6'b101010, '0); drive(1'b0, 10);
      chk(word_o == 6'b101010, "R7 word before stuck", int'(word_o), 'h2a);
      drive(1'b1, CPB);
      send_word(6'b110011, '0); drive(1'b1, 10);
      chk(exp_q.size() == 0, "R7 no extra word", exp_q.size(), 0);

      // R6 hold
      chk(word_o == 6'b110011, "R6 word held", int'(word_o), 'h33);

      // R1 reset mid-frame
      drive(1'b0, CPB); drive(1'b1, 3);
      rst_n = 1'b0;
      @(negedge clk);
      chk(word_o == '0 && !word_vld_o, "R1 mid-frame reset", int'(word_o), 0);
      drive(1'b1, 3);
      rst_n = 1'b1;
      drive(1'b1, 4);
      send_word(6'b001110, '0); drive(1'b1, 20);

      chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
      chk(err_seen == err_exp, "R4 error count", err_seen, err_exp);
      chk(word_o == 6'b001110, "R2 frame after reset", int'(word_o), 'h0e);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule